// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Selector

This block holds approximate recency state for every set of a set-associative cache and names the way that should be evicted next. A cache controller reports each hit or fill by giving the set index and the way touched, with a one-cycle valid strobe. Separately, it presents a set index on a query port and reads back a victim way combinationally.

Each set keeps a binary tree of WAYS-1 bits. The default is 8 ways, which gives 7 bits per set. Node 0 is the root. The children of node n are 2n+1 (lower half) and 2n+2 (upper half), and the last level chooses within a pair of ways. A bit value of 0 steers the victim search toward the lower-numbered half, and 1 steers it toward the upper half.

An access rewrites only the bits on the path to the accessed way, so that each one steers away from that way. A synchronous clear, and likewise reset, returns every bit to 0. The victim query reads the registered state, so an update in the same cycle is not yet visible to it. With WAYS=2 the tree reduces to one bit per set, which is exact LRU.

Top module: `plru_tree`

## Requirements
- R1: After reset, the victim for every set is way 0, because all tree bits are 0.
- R2: After an access to way w of set s, a query of set s returns a way other than w until s is accessed again or cleared.
- R3: After an access to way w of set s, the root of set s steers to the half that does not hold w, so the top bit of the victim differs from the top bit of w.
- R4: The victim is found by starting at the root and going down one level at a time. At each node, bit 0 selects the lower-numbered half and bit 1 selects the upper half. The victim way is the sequence of chosen bits, most significant first.
- R5: An access changes only the WW bits on its path. Example: access way 0, then access way 4, of one set; the victim is then way 2.
- R6: An access to one set leaves the victim of every other set unchanged.
- R7: When an update and a query hit the same set in the same cycle, the query returns the victim from the state before that update.
- R8: A clear that is high at a clock edge zeroes all tree bits of every set and takes priority over an update in the same cycle. From the next cycle on, every victim is way 0.
- R9: While upd_valid and clear are both low, no state changes, and the victim for any set stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of all tree bits |
| upd_valid | input | 1 | Access strobe |
| upd_set | input | SW | Set index of the access |
| upd_way | input | WW | Way that was hit or filled |
| query_set | input | SW | Set whose victim is requested |
| victim_way | output | WW | Way to replace in query_set |

## Verification
The in-line assertions check four things on every cycle:
- A just-accessed way is never offered as the victim of its set.
- The root steers away from the half that holds that way.
- A clear leaves way 0 as the victim everywhere.
- The victim for an unchanged query set holds steady while the block is idle.

Only the bench scenarios can show the rest. These are the exact victim chosen after long access sequences, that off-path bits survive an access, that other sets are isolated, and that a query in the same cycle as an update sees the old state. For these the bench compares every cycle against a model that stores, per tree level, which half was accessed last.

// File: rtl/plru_tree.sv
module plru_tree #(
  parameter int SETS = 64,
  parameter int WAYS = 8,
  localparam int SW = $clog2(SETS),
  localparam int WW = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          upd_valid,
  input  logic [SW-1:0] upd_set,
  input  logic [WW-1:0] upd_way,
  input  logic [SW-1:0] query_set,
  output logic [WW-1:0] victim_way
);

  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] path_next;
  logic [NODES-1:0] cur;

  always_comb begin
    int node;
    path_next = tree_q[upd_set];
    node = 0;
    for (int l = 0; l < WW; l++) begin
      path_next[node] = ~upd_way[WW-1-l];
      node = 2*node + 1 + int'(upd_way[WW-1-l]);
    end
  end

  assign cur = tree_q[query_set];

  always_comb begin
    int node;
    victim_way = '0;
    node = 0;
    for (int l = 0; l < WW; l++) begin
      victim_way[WW-1-l] = cur[node];
      node = 2*node + 1 + int'(cur[node]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (clear) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (upd_valid) begin
      tree_q[upd_set] <= path_next;
    end
  end

  AST_HIT_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !clear) |=> (query_set != $past(upd_set) || victim_way != $past(upd_way))); // R2
  AST_ROOT_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !clear) |=> (query_set != $past(upd_set) || victim_way[WW-1] != $past(upd_way[WW-1]))); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (victim_way == '0)); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && !clear) |=> (query_set != $past(query_set) || victim_way == $past(victim_way))); // R9

endmodule

// File: tb/sim_plru_tree.sv
`timescale 1ns/1ps
module sim_plru_tree;
  localparam int SETS = 64;
  localparam int WAYS = 8;
  localparam int SW = $clog2(SETS);
  localparam int WW = $clog2(WAYS);

  logic clk = 0, rst_n = 0, clear = 0, upd_valid = 0;
  logic [SW-1:0] upd_set = '0, query_set = '0;
  logic [WW-1:0] upd_way = '0;
  logic [WW-1:0] victim_way;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  int lastacc [SETS][WW][WAYS];

  always #2.5 clk = ~clk;

  plru_tree #(.SETS(SETS), .WAYS(WAYS)) u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .upd_valid(upd_valid),
    .upd_set(upd_set), .upd_way(upd_way), .query_set(query_set),
    .victim_way(victim_way));

  function automatic int m_victim(int s);
    int v = 0;
    for (int l = 0; l < WW; l++) v = v*2 + (1 - lastacc[s][l][v]);
    return v;
  endfunction

  task automatic m_clear();
    for (int s = 0; s < SETS; s++)
      for (int l = 0; l < WW; l++)
        for (int g = 0; g < WAYS; g++) lastacc[s][l][g] = 1;
  endtask

  task automatic m_access(int s, int w);
    for (int l = 0; l < WW; l++) lastacc[s][l][w >> (WW-l)] = (w >> (WW-1-l)) & 1;
  endtask

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: victim actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: inputs set after negedge, output compared with model before posedge
  task automatic step(bit v, int s, int w, int q, bit c, string tag);
    upd_valid = v; upd_set = SW'(s); upd_way = WW'(w); query_set = SW'(q); clear = c;
    #1;
    chk(int'(victim_way), m_victim(q), tag);
    @(posedge clk);
    if (c) m_clear();
    else if (v) m_access(s, w);
    @(negedge clk);
  endtask

  task automatic expect_v(int q, int exp, string tag);
    upd_valid = 0; clear = 0; query_set = SW'(q);
    #1;
    chk(int'(victim_way), exp, tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int r;
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int q = 0; q < SETS; q += 9) expect_v(q, 0, "R1 reset");
    // R3/R4 single access steers root
    step(1, 5, 0, 5, 0, "R4 model");
    expect_v(5, 4, "R3 root away");
    // R5 off-path bits kept
    step(1, 5, 4, 5, 0, "R4 model");
    expect_v(5, 2, "R5 off-path");
    // R4 sweep 0..7 yields way 0
    for (int w = 0; w < WAYS; w++) step(1, 9, w, 9, 0, "R4 model");
    expect_v(9, 0, "R4 sweep");
    // R6 other sets untouched
    expect_v(10, 0, "R6 other set");
    expect_v(5, 2, "R6 other set");
    // R7 same-cycle update and query return old victim
    step(1, 5, 2, 5, 0, "R7 same cycle");
    chk(m_victim(5), 6, "R2 model sanity");
    expect_v(5, 6, "R2 after hit");
    // R9 idle keeps state
    repeat (5) step(0, 5, 6, 5, 0, "R9 idle");
    expect_v(5, 6, "R9 idle");
    // R8 clear beats update
    step(1, 5, 0, 5, 1, "R8 clear cycle");
    expect_v(5, 0, "R8 clear");
    expect_v(9, 0, "R8 clear");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int s, q;
      s = $urandom_range(0, 3);
      q = ($urandom_range(0, 1) == 1) ? s : $urandom_range(0, 3);
      r = $urandom_range(0, 99);
      step(r < 80, s, $urandom_range(0, WAYS-1), q, r == 99, "R4 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule